// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves one translation miss at a time. It takes a 32-bit virtual address with the current context value and reads page table entries from physical memory over a request/response port. It returns either a 4 Kbyte mapping or a 2 Mbyte mapping in a 40-bit physical space, or a page fault. The context value holds the upper 27 bits of an 8 Kbyte aligned first-level table. The walker samples it when it accepts the miss, so software may rewrite it at any later time.

A first-level entry either maps a 2 Mbyte page directly or points to a 4 Kbyte aligned second-level table. That table holds 512 eight-byte entries, each mapping a 4 Kbyte page. Tables may sit anywhere in physical memory. The walk result lasts a single cycle and goes to the requesting translation buffer.

Top module: `pt_walker`

## Requirements
- R1: After reset, `miss_ready` is 1, `mem_req_valid` is 0 and `res_valid` is 0.
- R2: The first fetch address is `{ctx, 13'b0} + va[31:21]*4`. The `ctx` and `va` values are those present when the miss is accepted; later changes on those inputs have no effect on the walk.
- R3: A first-level entry is `mem_rsp_data[31:0]`: bit 31 = valid, bit 30 = big page, bits 18:0 = 2 Mbyte page number. If valid and big, the walk ends with `res_big`=1, `res_ppn` = that 19-bit number zero-extended and `res_paddr = {entry[18:0], va[20:0]}`, and no second fetch is made.
- R4: If the first-level entry is valid and not big, bits 27:0 are a 4 Kbyte aligned table base. The second fetch address is `{entry[27:0], 12'b0} + va[20:12]*8`.
- R5: A second-level entry is `mem_rsp_data[63:0]`: bit 63 = valid, bits 27:0 = page number. If valid, the result has `res_big`=0, `res_ppn` = bits 27:0 and `res_paddr = {ppn, va[11:0]}`.
- R6: A clear valid bit ends the walk with `res_fault`=1 and `res_big`=0. `res_fault_lvl` is 0 for a first-level fault and 1 for a second-level fault. The big bit of an invalid first-level entry is ignored. No further fetch follows a fault.
- R7: Only one walk is outstanding. `miss_ready` is 0 from acceptance until the result cycle. It is 1 in the result cycle, and a miss accepted there starts its first fetch on the next cycle.
- R8: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address stay unchanged.
- R9: `res_valid` is a one-cycle pulse per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| miss_valid | input | 1 | Translation miss request |
| miss_ready | output | 1 | Walker can accept a miss |
| miss_vaddr | input | 32 | Virtual address that missed |
| ctx_base | input | 27 | Context value: upper bits of first-level table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 40 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry data (first level uses bits 31:0) |
| res_valid | output | 1 | Walk result pulse |
| res_fault | output | 1 | Walk ended in a page fault |
| res_fault_lvl | output | 1 | Fault level: 0 first, 1 second |
| res_big | output | 1 | Result is a 2 Mbyte page |
| res_ppn | output | 28 | Physical page number of the mapping |
| res_paddr | output | 40 | Translated physical address |

## Verification
A walk can deliver its result in the same cycle that the next miss is accepted, because the result state also raises `miss_ready`. The bench finishes a 2 Mbyte walk and holds a new miss, with a different context and address, on the input during that result cycle. It then checks three things: the old result is correct, the pulse ends after one cycle, and the next fetch address is built from the newly sampled context.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 40,
  parameter int CTX_W = 27,
  parameter int RSP_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [VA_W-1:0]   miss_vaddr,
  input  logic [CTX_W-1:0]  ctx_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [RSP_W-1:0]  mem_rsp_data,
  output logic              res_valid,
  output logic              res_fault,
  output logic              res_fault_lvl,
  output logic              res_big,
  output logic [PA_W-13:0]  res_ppn,
  output logic [PA_W-1:0]   res_paddr
);
  localparam int PG_SH     = 12;
  localparam int BIG_SH    = 21;
  localparam int PPN_W     = PA_W - PG_SH;
  localparam int BIG_PPN_W = PA_W - BIG_SH;
  localparam int CTX_SH    = PA_W - CTX_W;
  localparam int L1_IDX_W  = VA_W - BIG_SH;
  localparam int L2_IDX_W  = BIG_SH - PG_SH;
  localparam int E1_V      = 31;
  localparam int E1_B      = 30;
  localparam int E2_V      = RSP_W - 1;

  typedef enum logic [2:0] {IDLE, FETCH_L1, WAIT_L1, FETCH_L2, WAIT_L2, DONE} st_t;

  st_t              st;
  logic [VA_W-1:0]  va_q;
  logic [CTX_W-1:0] ctx_q;
  logic [PPN_W-1:0] tbl_q;
  logic [PPN_W-1:0] ppn_q;
  logic             big_q, fault_q, lvl_q;

  logic             accept;
  logic [PA_W-1:0]  l1_addr, l2_addr;
  logic             unused_bits;

  assign miss_ready    = (st == IDLE) || (st == DONE);
  assign accept        = miss_valid && miss_ready;
  assign mem_req_valid = (st == FETCH_L1) || (st == FETCH_L2);
  assign res_valid     = (st == DONE);

  assign l1_addr = {ctx_q, {CTX_SH{1'b0}}}
                 + {{(PA_W-L1_IDX_W-2){1'b0}}, va_q[VA_W-1:BIG_SH], 2'b00};
  assign l2_addr = {tbl_q, {PG_SH{1'b0}}}
                 + {{(PA_W-L2_IDX_W-3){1'b0}}, va_q[BIG_SH-1:PG_SH], 3'b000};
  assign mem_req_addr = (st == FETCH_L2) ? l2_addr : l1_addr;

  assign res_fault     = fault_q;
  assign res_fault_lvl = lvl_q;
  assign res_big       = big_q;
  assign res_ppn       = ppn_q;
  assign res_paddr     = big_q ? {ppn_q[BIG_PPN_W-1:0], va_q[BIG_SH-1:0]}
                               : {ppn_q, va_q[PG_SH-1:0]};

  assign unused_bits = ^{mem_rsp_data[RSP_W-2:32], mem_rsp_data[E1_B-1:PPN_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      va_q    <= '0;
      ctx_q   <= '0;
      tbl_q   <= '0;
      ppn_q   <= '0;
      big_q   <= 1'b0;
      fault_q <= 1'b0;
      lvl_q   <= 1'b0;
    end else begin
      case (st)
        IDLE, DONE: begin
          if (accept) begin
            st      <= FETCH_L1;
            va_q    <= miss_vaddr;
            ctx_q   <= ctx_base;
            ppn_q   <= '0;
            big_q   <= 1'b0;
            fault_q <= 1'b0;
            lvl_q   <= 1'b0;
          end else begin
            st <= IDLE;
          end
        end
        FETCH_L1: if (mem_req_ready) st <= WAIT_L1;
        WAIT_L1: begin
          if (mem_rsp_valid) begin
            if (!mem_rsp_data[E1_V]) begin
              fault_q <= 1'b1;
              lvl_q   <= 1'b0;
              st      <= DONE;
            end else if (mem_rsp_data[E1_B]) begin
              big_q <= 1'b1;
              ppn_q <= {{(PPN_W-BIG_PPN_W){1'b0}}, mem_rsp_data[BIG_PPN_W-1:0]};
              st    <= DONE;
            end else begin
              tbl_q <= mem_rsp_data[PPN_W-1:0];
              st    <= FETCH_L2;
            end
          end
        end
        FETCH_L2: if (mem_req_ready) st <= WAIT_L2;
        WAIT_L2: begin
          if (mem_rsp_valid) begin
            if (!mem_rsp_data[E2_V]) begin
              fault_q <= 1'b1;
              lvl_q   <= 1'b1;
            end else begin
              ppn_q <= mem_rsp_data[PPN_W-1:0];
            end
            st <= DONE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  a_r7_one_walk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> !miss_ready);

  a_r7_busy_while_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !miss_ready);

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  a_r6_fault_not_big: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> !res_big);
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [31:0] miss_vaddr = '0;
  logic [26:0] ctx_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [39:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        res_valid, res_fault, res_fault_lvl, res_big;
  logic [27:0] res_ppn;
  logic [39:0] res_paddr;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_vaddr(miss_vaddr), .ctx_base(ctx_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_fault(res_fault), .res_fault_lvl(res_fault_lvl),
    .res_big(res_big), .res_ppn(res_ppn), .res_paddr(res_paddr)
  );

  localparam int NV = 6;
  localparam logic [26:0] V_CTX [NV] = '{27'h0000001, 27'h7FFFFFF, 27'h0123456,
                                         27'h2000000, 27'h0040404, 27'h1555555};
  localparam logic [31:0] V_VA  [NV] = '{32'h40601234, 32'hFFFFFFFF, 32'h00000000,
                                         32'h80203ABC, 32'h7FE00FFF, 32'h00155FFF};
  localparam logic [31:0] V_E1  [NV] = '{32'hC001ABCD, 32'h8ABCDEF1, 32'h00000000,
                                         32'h80000001, 32'h40000005, 32'hBFFFFFFE};
  localparam logic [63:0] V_E2  [NV] = '{64'h0, 64'h800000000FEDCBA9, 64'h0,
                                         64'h0000000000000055, 64'h0, 64'hFFFFFFFFF1234567};

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] l1_addr(input logic [26:0] c, input logic [31:0] v);
    return {c, 13'b0} + {27'b0, v[31:21], 2'b00};
  endfunction

  function automatic logic [39:0] l2_addr(input logic [31:0] e, input logic [31:0] v);
    return {e[27:0], 12'b0} + {28'b0, v[20:12], 3'b000};
  endfunction

  task automatic issue(input logic [26:0] c, input logic [31:0] v);
    @(negedge clk);
    miss_valid = 1'b1; miss_vaddr = v; ctx_base = c;
    for (int k = 0; k < 50 && !miss_ready; k++) @(negedge clk);
    @(posedge clk);
    #1;
    miss_valid = 1'b0; miss_vaddr = ~v; ctx_base = ~c;
  endtask

  task automatic serve(input logic [39:0] ea, input logic [63:0] d, input int stall,
                       input string req);
    @(negedge clk);
    for (int k = 0; k < 50 && !mem_req_valid; k++) @(negedge clk);
    chk(mem_req_valid && mem_req_addr == ea, req, {24'b0, mem_req_addr}, {24'b0, ea});
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(mem_req_valid && mem_req_addr == ea, "R8 hold", {24'b0, mem_req_addr}, {24'b0, ea});
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_data = d;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
  endtask

  task automatic collect(input bit ef, input bit el, input bit eb, input logic [27:0] eppn,
                         input logic [39:0] epa, input string req);
    for (int k = 0; k < 20 && !res_valid; k++) @(negedge clk);
    chk(res_valid && !miss_valid ? miss_ready : 1'b1, "R7 ready in result", {63'b0, miss_ready}, 64'd1);
    chk(res_valid && res_fault == ef, req, {63'b0, res_fault}, {63'b0, ef});
    if (ef) chk(res_fault_lvl == el && !res_big, {req, " R6 level"},
                {62'b0, res_big, res_fault_lvl}, {63'b0, el});
    else begin
      chk(res_big == eb && res_ppn == eppn, req, {35'b0, res_big, res_ppn}, {35'b0, eb, eppn});
      chk(res_paddr == epa, req, {24'b0, res_paddr}, {24'b0, epa});
    end
    @(negedge clk);
    chk(!res_valid, "R9 pulse", {63'b0, res_valid}, 64'd0);
    chk(!mem_req_valid, "R6 no extra fetch", {63'b0, mem_req_valid}, 64'd0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(miss_ready && !mem_req_valid && !res_valid, "R1 reset",
        {61'b0, miss_ready, mem_req_valid, res_valid}, 64'h4);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v, e1;
      logic [63:0] e2;
      v = V_VA[i]; e1 = V_E1[i]; e2 = V_E2[i];
      issue(V_CTX[i], v);
      chk(!miss_ready, "R7 busy", {63'b0, miss_ready}, 64'd0);
      serve(l1_addr(V_CTX[i], v), {32'hDEADBEEF, e1}, i % 3, "R2 first address");
      if (!e1[31]) begin
        collect(1'b1, 1'b0, 1'b0, '0, '0, "R6 first-level fault");
      end else if (e1[30]) begin
        collect(1'b0, 1'b0, 1'b1, {9'b0, e1[18:0]}, {e1[18:0], v[20:0]}, "R3 big page");
      end else begin
        serve(l2_addr(e1, v), e2, (i + 1) % 3, "R4 second address");
        if (!e2[63]) collect(1'b1, 1'b1, 1'b0, '0, '0, "R6 second-level fault");
        else collect(1'b0, 1'b0, 1'b0, e2[27:0], {e2[27:0], v[11:0]}, "R5 small page");
      end
    end

    // R7: new miss accepted in the result cycle of a big-page walk
    issue(V_CTX[0], V_VA[0]);
    serve(l1_addr(V_CTX[0], V_VA[0]), {32'h0, V_E1[0]}, 0, "R2 first address");
    chk(res_valid && miss_ready && res_big, "R7 result with ready",
        {61'b0, res_valid, miss_ready, res_big}, 64'h7);
    chk(res_paddr == {V_E1[0][18:0], V_VA[0][20:0]}, "R3 big page overlap",
        {24'b0, res_paddr}, {24'b0, V_E1[0][18:0], V_VA[0][20:0]});
    miss_valid = 1'b1; miss_vaddr = V_VA[1]; ctx_base = V_CTX[1];
    @(negedge clk);
    miss_valid = 1'b0; ctx_base = 27'h0;
    chk(!res_valid, "R9 pulse overlap", {63'b0, res_valid}, 64'd0);
    chk(mem_req_valid && mem_req_addr == l1_addr(V_CTX[1], V_VA[1]), "R7 back-to-back fetch",
        {24'b0, mem_req_addr}, {24'b0, l1_addr(V_CTX[1], V_VA[1])});
    serve(l1_addr(V_CTX[1], V_VA[1]), {32'h0, V_E1[1]}, 1, "R2 first address");
    serve(l2_addr(V_E1[1], V_VA[1]), V_E2[1], 0, "R4 second address");
    collect(1'b0, 1'b0, 1'b0, V_E2[1][27:0], {V_E2[1][27:0], V_VA[1][11:0]}, "R5 after overlap");

    summary();
  end
endmodule